// File: doc/BRIEF.md
# Subtract Instruction Execution Unit

This block carries out the two subtract operations of a small 8-bit accumulator-style processor core. One form subtracts the working register (W) from an 8-bit immediate carried in the instruction word. The other form subtracts W from a byte of the block's own banked data memory. Its result goes either to W or back to the same memory byte. Every executed subtract updates a five-bit status word: negative, signed overflow, zero, digit carry and carry. Both carries are inverted borrows.

An operation starts when a one-cycle start strobe arrives while the unit is idle. The unit latches the 16-bit instruction word and the current W value. It then steps through four phases in a fixed order: decode, operand read, compute and write-back. In the write-back phase it raises `done` for one cycle, and it pulses `w_we` with the new W value when W is the destination.

The data memory is addressed by the 8-bit byte address in the instruction. A 4-bit bank register supplies the bank. An instruction bit can bypass the bank register and use a fixed split instead: the low half of the address space maps to bank 0 and the high half to the top bank. Fetch, program counting, other opcodes and interrupts lie outside this block.

Top module: `sub_exec_unit`

## Requirements
- R1: After reset, `busy`, `done` and `w_we` are 0, `flags` is 0, the bank register is 0 and every data-memory byte reads as 0.
- R2: An instruction word whose upper byte is 0x08 computes (low byte k) minus W modulo 256 and presents the result on `w_out` with `w_we` high in the `done` cycle.
- R3: An instruction word whose bits [15:10] are 6'b010111 reads the memory byte selected by bits [7:0] and computes that byte minus W modulo 256.
- R4: For the memory form, bit 9 set to 1 writes the result back to the selected memory byte and keeps `w_we` low. Bit 9 set to 0 puts the result on `w_out` with `w_we` high and leaves memory unchanged.
- R5: For the memory form, bit 8 set to 1 selects bank (bank register mod NUM_BANKS). Bit 8 set to 0 ignores the bank register and uses bank 0 for byte addresses below 0x80 and bank 2**BANK_W-1 (mod NUM_BANKS) for the rest.
- R6: `flags[0]` (carry) is 1 when the minuend is at least W, which means no borrow. `flags[2]` (zero) is 1 when the 8-bit result is 0.
- R7: `flags[4]` (negative) equals bit 7 of the result. `flags[3]` (overflow) is 1 when the signed 8-bit subtraction overflows. `flags[1]` (digit carry) is 1 when the low nibble of the minuend is at least the low nibble of W.
- R8: A start strobe sampled while idle gives `busy` high from the next cycle. `done` is high in exactly the fourth cycle after the accepting edge. `flags` takes its new value at the edge that ends the `done` cycle. A start strobe seen while busy is ignored.
- R9: An instruction word that matches neither form still completes the four phases and raises `done`, but writes neither W nor memory and leaves `flags` unchanged.
- R10: `bsr_we` high at a clock edge loads `bsr_din` into the bank register, and later memory-form instructions with bit 8 set use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| instr | input | 16 | Instruction word, sampled at the accepting edge |
| w_in | input | 8 | Working register value, sampled at the accepting edge |
| bsr_we | input | 1 | Load enable for the bank register |
| bsr_din | input | BANK_W | New bank register value |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Write-back phase of the current operation |
| w_we | output | 1 | W must take `w_out` (only while `done`) |
| w_out | output | 8 | Subtraction result |
| flags | output | 5 | {negative, overflow, zero, digit carry, carry} |

## Verification
The bench builds the unit with its default parameters: a 4-bit bank register over four physical banks. With these values a bank register above 3 wraps onto a lower physical bank, and the access-bank high half (bank 15) lands on physical bank 3. Both wrap paths can therefore be reached and checked against the reference model. The immediate form is swept over every literal against a spread of W values, so every carry, digit-carry, overflow and zero boundary is reached. Memory contents are set and read back only through subtract instructions.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;

   localparam int DATA_W  = 8;
   localparam int INSTR_W = 16;
   localparam int NIB_W   = DATA_W / 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEC,
      PH_READ,
      PH_PROC,
      PH_WRITE
   } phase_t;

   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } flags_t;

   typedef struct packed {
      logic              valid;
      logic              is_mem;
      logic              to_mem;
      logic              use_bank_reg;
      logic [DATA_W-1:0] field;
   } dec_t;

endpackage

// File: rtl/sub_decode.sv
module sub_decode
   import sub_exec_pkg::*;
#(
   parameter logic [7:0] LIT_OPC = 8'h08,
   parameter logic [5:0] MEM_OPC = 6'b010111
) (
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);
   logic hit_lit, hit_mem;

   assign hit_lit = (instr[15:8] == LIT_OPC);
   assign hit_mem = (instr[15:10] == MEM_OPC);

   always_comb begin
      dec.valid        = hit_lit | hit_mem;
      dec.is_mem       = hit_mem;
      dec.to_mem       = hit_mem & instr[9];
      dec.use_bank_reg = hit_mem & instr[8];
      dec.field        = instr[7:0];
   end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
   import sub_exec_pkg::*;
(
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   output logic [DATA_W-1:0] result,
   output flags_t            fl
);
   logic [DATA_W:0] full_diff;
   logic [NIB_W:0]  nib_diff;

   always_comb begin
      full_diff = {1'b0, minuend} - {1'b0, subtrahend};
      nib_diff  = {1'b0, minuend[NIB_W-1:0]} - {1'b0, subtrahend[NIB_W-1:0]};
      result    = full_diff[DATA_W-1:0];
      fl.c      = ~full_diff[DATA_W];
      fl.dc     = ~nib_diff[NIB_W];
      fl.z      = (full_diff[DATA_W-1:0] == '0);
      fl.n      = full_diff[DATA_W-1];
      fl.ov     = (minuend[DATA_W-1] ^ subtrahend[DATA_W-1])
                & (full_diff[DATA_W-1] ^ minuend[DATA_W-1]);
   end
endmodule

// File: rtl/sub_bankmem.sv
module sub_bankmem
   import sub_exec_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int NUM_BANKS = 4,
   parameter int SPLIT     = 128,
   localparam int PB_W      = $clog2(NUM_BANKS),
   localparam int PA_W      = PB_W + DATA_W,
   localparam int MEM_DEPTH = NUM_BANKS << DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsr_we,
   input  logic [BANK_W-1:0] bsr_din,
   input  logic              sel_use_bank_reg,
   input  logic [DATA_W-1:0] sel_byte,
   output logic [PA_W-1:0]   sel_addr,
   input  logic [PA_W-1:0]   rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [PA_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [BANK_W-1:0] bsr_q;
   logic [BANK_W-1:0] bank_sel;
   logic [PB_W-1:0]   phys_bank;
   logic [DATA_W-1:0] mem [MEM_DEPTH];

   always_comb begin
      if (sel_use_bank_reg)        bank_sel = bsr_q;
      else if (sel_byte >= SPLIT)  bank_sel = '1;
      else                         bank_sel = '0;
   end

   generate
      if (NUM_BANKS == (1 << BANK_W)) begin : g_full_banks
         assign phys_bank = bank_sel;
      end else begin : g_wrapped_banks
         assign phys_bank = bank_sel[PB_W-1:0];
      end
   endgenerate

   assign sel_addr = {phys_bank, sel_byte};
   assign rd_data  = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bsr_q <= '0;
         for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      end else begin
         if (bsr_we) bsr_q <= bsr_din;
         if (wr_en)  mem[wr_addr] <= wr_data;
      end
   end

   p_bsr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bsr_we |=> (bsr_q == $past(bsr_din)));
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
   import sub_exec_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int NUM_BANKS = 4,
   parameter int SPLIT     = 128,
   localparam int PB_W = $clog2(NUM_BANKS),
   localparam int PA_W = PB_W + DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [DATA_W-1:0]   w_in,
   input  logic                bsr_we,
   input  logic [BANK_W-1:0]   bsr_din,
   output logic                busy,
   output logic                done,
   output logic                w_we,
   output logic [DATA_W-1:0]   w_out,
   output logic [4:0]          flags
);
   generate
      if (NUM_BANKS < 2 || NUM_BANKS > (1 << BANK_W) ||
          (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two in [2, 2**BANK_W]");
      end
      if (SPLIT < 1 || SPLIT > 255) begin : g_bad_split
         $error("SPLIT must lie in [1, 255]");
      end
   endgenerate

   phase_t              phase;
   logic [INSTR_W-1:0]  instr_q;
   logic [DATA_W-1:0]   w_q, opnd_q, res_q;
   logic [PA_W-1:0]     addr_q;
   dec_t                dec, dec_q;
   flags_t              flags_q, fl_new_q, alu_fl;
   logic [DATA_W-1:0]   alu_res, rd_data;
   logic [PA_W-1:0]     sel_addr;
   logic                mem_we;

   sub_decode u_dec (.instr(instr_q), .dec(dec));

   sub_bankmem #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SPLIT(SPLIT)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .bsr_we(bsr_we), .bsr_din(bsr_din),
      .sel_use_bank_reg(dec_q.use_bank_reg), .sel_byte(dec_q.field),
      .sel_addr(sel_addr),
      .rd_addr(sel_addr), .rd_data(rd_data),
      .wr_en(mem_we), .wr_addr(addr_q), .wr_data(res_q)
   );

   sub_alu u_alu (.minuend(opnd_q), .subtrahend(w_q), .result(alu_res), .fl(alu_fl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         instr_q  <= '0;
         w_q      <= '0;
         opnd_q   <= '0;
         res_q    <= '0;
         addr_q   <= '0;
         dec_q    <= '0;
         flags_q  <= '0;
         fl_new_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               instr_q <= instr;
               w_q     <= w_in;
               phase   <= PH_DEC;
            end
            PH_DEC: begin
               dec_q <= dec;
               phase <= PH_READ;
            end
            PH_READ: begin
               opnd_q <= dec_q.is_mem ? rd_data : dec_q.field;
               addr_q <= sel_addr;
               phase  <= PH_PROC;
            end
            PH_PROC: begin
               res_q    <= alu_res;
               fl_new_q <= alu_fl;
               phase    <= PH_WRITE;
            end
            PH_WRITE: begin
               if (dec_q.valid) flags_q <= fl_new_q;
               phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy   = (phase != PH_IDLE);
   assign done   = (phase == PH_WRITE);
   assign mem_we = done & dec_q.valid & dec_q.to_mem;
   assign w_we   = done & dec_q.valid & ~dec_q.to_mem;
   assign w_out  = res_q;
   assign flags  = flags_q;

   p_done_after_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(phase) == PH_PROC));
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_one_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      w_we |-> (done && !mem_we));
   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(flags_q));
   p_zero_has_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fl_new_q.z) |-> fl_new_q.c);
endmodule

// File: tb/tb_sub_exec_unit.sv
module tb_sub_exec_unit;
   localparam int CLK_PERIOD = 10;
   localparam int BANK_W     = 4;
   localparam int NUM_BANKS  = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0;
   logic [15:0] instr = '0;
   logic [7:0]  w_in = '0;
   logic        bsr_we = 0;
   logic [3:0]  bsr_din = '0;
   logic        busy, done, w_we;
   logic [7:0]  w_out;
   logic [4:0]  flags;

   int n_checks = 0;
   int n_fail   = 0;

   int model_mem [NUM_BANKS*256];
   int model_bsr = 0;
   int model_flags = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sub_exec_unit #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .w_in(w_in),
      .bsr_we(bsr_we), .bsr_din(bsr_din), .busy(busy), .done(done),
      .w_we(w_we), .w_out(w_out), .flags(flags)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int ref_flags(input int a, input int b);
      int d, sd, res, f;
      d   = a - b;
      res = d & 255;
      sd  = ((a >= 128) ? a - 256 : a) - ((b >= 128) ? b - 256 : b);
      f   = 0;
      if (d >= 0)                        f |= 1;
      if ((a % 16) - (b % 16) >= 0)      f |= 2;
      if (res == 0)                      f |= 4;
      if (sd > 127 || sd < -128)         f |= 8;
      if (res >= 128)                    f |= 16;
      return f;
   endfunction

   function automatic int ref_addr(input int a_bit, input int f);
      int bank;
      if (a_bit != 0)  bank = model_bsr;
      else             bank = (f >= 128) ? 15 : 0;
      return (bank % NUM_BANKS) * 256 + f;
   endfunction

   // Runs one operation; poke drives a second start while busy (must be ignored)
   task automatic run_op(input logic [15:0] iw, input int w, input bit poke);
      int  kind, res, fexp, addr, minu;
      bit  to_w;
      @(negedge clk);
      start = 1; instr = iw; w_in = w[7:0];
      @(negedge clk);
      start = poke; instr = 16'h08FF; w_in = 8'h55;
      check("R8 busy after accept", busy, 1);
      check("R8 done in Q1", done, 0);
      @(negedge clk);
      start = 0;
      check("R8 done in Q2", done, 0);
      @(negedge clk);
      check("R8 done in Q3", done, 0);
      @(negedge clk);
      check("R8 done in Q4", done, 1);
      if (iw[15:8] == 8'h08)         kind = 1;
      else if (iw[15:10] == 6'h17)   kind = 2;
      else                           kind = 0;
      addr = ref_addr(iw[8], iw[7:0]);
      minu = (kind == 1) ? iw[7:0] : model_mem[addr];
      res  = (minu - w) & 255;
      fexp = ref_flags(minu, w);
      to_w = (kind == 1) || (kind == 2 && iw[9] == 0);
      if (kind == 0) begin
         check("R9 no W write on unknown opcode", w_we, 0);
      end else if (kind == 1) begin
         check("R2 w_we literal", w_we, 1);
         check("R2 literal result", w_out, res);
      end else begin
         check("R4 w_we follows dest bit", w_we, to_w);
         if (to_w) check("R3 memory-form result", w_out, res);
      end
      if (kind == 2 && !to_w) model_mem[addr] = res;
      if (kind != 0) model_flags = fexp;
      @(negedge clk);
      check("R8 idle after write", busy, 0);
      check("R8 done single", done, 0);
      check("R6 carry", flags[0], model_flags & 1);
      check("R6 zero", flags[2], (model_flags >> 2) & 1);
      check("R7 digit carry", flags[1], (model_flags >> 1) & 1);
      check("R7 overflow", flags[3], (model_flags >> 3) & 1);
      check("R7 negative", flags[4], (model_flags >> 4) & 1);
      if (kind == 0) check("R9 flags unchanged", flags, model_flags);
   endtask

   task automatic load_bsr(input int v);
      @(negedge clk);
      bsr_we = 1; bsr_din = v[3:0];
      @(negedge clk);
      bsr_we = 0;
      model_bsr = v;
   endtask

   // Reads a memory byte through the W destination with W=0
   task automatic read_byte(input int a_bit, input int f, input string req);
      logic [15:0] iw;
      int exp;
      exp = model_mem[ref_addr(a_bit, f)];
      iw = {6'b010111, 1'b0, a_bit[0], f[7:0]};
      run_op(iw, 0, 0);
      check(req, w_out, exp);
   endtask

   // Writes value v to a memory byte currently holding old: f := f - W
   task automatic write_byte(input int a_bit, input int f, input int v);
      int old;
      old = model_mem[ref_addr(a_bit, f)];
      run_op({6'b010111, 1'b1, a_bit[0], f[7:0]}, (old - v) & 255, 0);
   endtask

   bit finished = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NUM_BANKS*256; i++) model_mem[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check("R1 busy at reset", busy, 0);
      check("R1 done at reset", done, 0);
      check("R1 w_we at reset", w_we, 0);
      check("R1 flags at reset", flags, 0);
      read_byte(0, 8'h20, "R1 memory clear bank0");
      read_byte(1, 8'hC3, "R1 memory clear via bank reg 0");

      // Literal form sweep
      for (int k = 0; k < 256; k++) begin
         for (int j = 0; j < 8; j++) run_op({8'h08, k[7:0]}, (j * 37 + k * 3) & 255, 0);
         run_op({8'h08, k[7:0]}, k, 0);
      end
      // Documented boundary pairs
      run_op(16'h0802, 2, 0);
      check("R6 2-2 zero", flags[2], 1);
      run_op(16'h0801, 2, 0);
      check("R7 1-2 negative", w_out, 8'hFF);

      // Memory form, destinations
      write_byte(0, 8'h10, 8'h33);
      read_byte(0, 8'h10, "R4 write-back to memory");
      run_op({6'b010111, 1'b0, 1'b0, 8'h10}, 8'h13, 0);
      read_byte(0, 8'h10, "R4 W destination leaves memory");

      // Bank selection
      load_bsr(2);
      write_byte(1, 8'h10, 8'hA5);
      read_byte(1, 8'h10, "R10 bank reg 2 write");
      read_byte(0, 8'h10, "R5 access low ignores bank reg");
      write_byte(0, 8'h90, 8'h7E);
      load_bsr(3);
      read_byte(1, 8'h90, "R5 access high is top bank");
      load_bsr(7);
      read_byte(1, 8'h90, "R5 bank reg wraps to physical bank");
      load_bsr(14);
      read_byte(1, 8'h10, "R10 bank reg 14 wraps to bank 2");

      // Memory-form arithmetic with stored operands
      for (int v = 0; v < 256; v += 15) begin
         write_byte(1, 8'h44, v);
         for (int w = 0; w < 256; w += 51)
            run_op({6'b010111, 1'b0, 1'b1, 8'h44}, w, 0);
      end

      // Unknown opcode and start while busy
      run_op(16'h0802, 2, 0);
      run_op(16'hFFFF, 8'h01, 0);
      run_op(16'h3C00, 8'h80, 0);
      run_op(16'h0810, 8'h05, 1);
      @(negedge clk);
      check("R8 start while busy ignored", done, 0);
      check("R8 no second operation", busy, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule